// File: doc/BRIEF.md
# ISA-to-IDE Sixteen-Bit Data Port Bridge

This bridge lets an 8-bit ISA-style host move 16-bit data words to and from an IDE/ATA drive. It decodes a relocatable window of sixteen host I/O ports. It passes the task-file registers through to the drive as single-byte accesses. Each 16-bit data word is split into two host byte cycles. The drive-side strobes are generated synchronously, and their setup and pulse widths are set by parameters. The host cycle is held until the drive access is over.

Two data-port modes are chosen by a static configuration input.

- Split-port mode uses two addresses. The low byte moves through the data port at offset 0. The high byte is held in a latch that the host reaches at offset 8.
- Toggle mode uses only offset 0 for both bytes. An internal byte-phase flip-flop decides which half is served. A host word IN or OUT therefore maps onto two consecutive byte cycles at the same address. Touching any other register of the window puts the flip-flop back into its first phase.

Top module: `isa_ide_bridge`

## Requirements
- R1: The window is selected only when `host_addr_i[9:4]` equals `base_i` and `host_aen_i` is low. An unselected cycle produces no drive access and never raises `host_rdy_o`. Changing `base_i` (for example from 30h to 36h) moves the window.
- R2: A host access to offsets 1 to 7 makes exactly one drive access, with `ide_da_o` equal to the offset and `ide_cs0_o` asserted. A read returns drive data bits 7:0. A write drives the host byte on bits 7:0 and zero on bits 15:8. The byte-phase flip-flop is unaffected in split-port mode.
- R3: In split-port mode, a read at offset 0 makes one 16-bit drive read, returns bits 7:0 and keeps bits 15:8 in the high latch. A following read at offset 8 returns that latch and makes no drive strobe.
- R4: In split-port mode, a write at offset 8 loads the high latch with no drive strobe. A following write at offset 0 makes exactly one drive write of {high latch, host byte}.
- R5: In toggle mode, the first read at offset 0 makes one 16-bit drive read and returns bits 7:0. The second read returns bits 15:8 and makes no drive strobe.
- R6: In toggle mode, the first write at offset 0 only stores the byte as the high half, with no strobe. The second write makes one drive write of {first byte, second byte}.
- R7: In toggle mode, any access to offsets 1 to 15 returns the byte-phase flip-flop to the first phase. The next data-port read then strobes the drive again and returns a low byte.
- R8: Every drive access holds `ide_cs0_o` for SETUP_CYC cycles before its strobe, and holds the strobe for PULSE_CYC cycles. The two strobes are never active together. The write data is stable while the write strobe is active.
- R9: `host_rdy_o` rises only after any drive access of the cycle has ended. It then stays high until the host removes its strobe.
- R10: While `rst_ni` is low, all drive strobes, `ide_cs0_o` and `host_rdy_o` are low. Reset also clears the byte phase and both latches, so a split-port read at offset 8 right after reset returns 00h.
- R11: Offsets 9 to 15 (and offset 8 in toggle mode) make no drive access. A read there returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| toggle_mode_i | input | 1 | 1 = toggle mode, 0 = split-port mode (static) |
| base_i | input | ADDR_W-4 | Window base, host address bits above bit 3 |
| host_addr_i | input | ADDR_W | Host I/O address |
| host_aen_i | input | 1 | Address enable; high marks a DMA cycle |
| host_ior_i | input | 1 | Host read strobe, active high |
| host_iow_i | input | 1 | Host write strobe, active high |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte, valid while host_rdy_o is high |
| host_rdy_o | output | 1 | Cycle complete; the host may end its strobe |
| ide_cs0_o | output | 1 | Drive register-block select, active high |
| ide_da_o | output | 3 | Drive register address |
| ide_dior_o | output | 1 | Drive read strobe, active high |
| ide_diow_o | output | 1 | Drive write strobe, active high |
| ide_wdata_o | output | 16 | Drive write data |
| ide_rdata_i | input | 16 | Drive read data |

## Verification
The checker watches every cycle for the drive-side timing rules of R8, the handshake of R9 and the AEN qualification of R1. Those rules are port-level relations that hold whatever the host does.

Byte ordering cannot be seen as a cycle-local property. This covers which half comes back first, the absence of a strobe on high-byte cycles, and the word assembled on a write. The phase reset after a status read is in the same position. Only the bench's scenarios show these, against a 16-bit drive register model and a count of drive strobes.

// File: rtl/isa_ide_pkg.sv
package isa_ide_pkg;
  typedef enum logic [2:0] {
    REG_NONE,
    REG_DATA,
    REG_TASK,
    REG_HIGH,
    REG_SPARE
  } reg_kind_e;

  typedef enum logic [1:0] {
    OP_RD_WORD,
    OP_RD_BYTE,
    OP_WR
  } drv_op_e;
endpackage

// File: rtl/isa_ide_decode.sv
module isa_ide_decode
  import isa_ide_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic [ADDR_W-5:0] base_i,
  input  logic              toggle_mode_i,
  output reg_kind_e         kind_o
);
  always_comb begin
    kind_o = REG_NONE;
    if (!aen_i && addr_i[ADDR_W-1:4] == base_i) begin
      if (addr_i[3:0] == 4'h0)                      kind_o = REG_DATA;
      else if (!addr_i[3])                          kind_o = REG_TASK;
      else if (addr_i[2:0] == 3'd0 && !toggle_mode_i) kind_o = REG_HIGH;
      else                                          kind_o = REG_SPARE;
    end
  end
endmodule

// File: rtl/isa_ide_drv_seq.sv
module isa_ide_drv_seq #(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        wr_i,
  input  logic [2:0]  da_i,
  input  logic [15:0] wdata_i,
  input  logic [15:0] ide_rdata_i,
  output logic        cs_o,
  output logic [2:0]  da_o,
  output logic        dior_o,
  output logic        diow_o,
  output logic [15:0] wdata_o,
  output logic        done_o,
  output logic [15:0] rdata_o
);
  localparam int MAX_CYC = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_PULSE} sq_e;

  sq_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      da_o    <= '0;
      wdata_o <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q    <= SQ_SETUP;
          cnt_q   <= '0;
          wr_q    <= wr_i;
          da_o    <= da_i;
          wdata_o <= wdata_i;
        end
        SQ_SETUP: begin
          if (cnt_q == CNT_W'(SETUP_CYC - 1)) begin
            st_q  <= SQ_PULSE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SQ_PULSE: begin
          if (done_o) st_q <= SQ_IDLE;
          else        cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign cs_o    = (st_q != SQ_IDLE);
  assign dior_o  = (st_q == SQ_PULSE) && !wr_q;
  assign diow_o  = (st_q == SQ_PULSE) && wr_q;
  assign done_o  = (st_q == SQ_PULSE) && (cnt_q == CNT_W'(PULSE_CYC - 1));
  assign rdata_o = ide_rdata_i;
endmodule

// File: rtl/isa_ide_bridge.sv
module isa_ide_bridge
  import isa_ide_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              toggle_mode_i,
  input  logic [ADDR_W-5:0] base_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_aen_i,
  input  logic              host_ior_i,
  input  logic              host_iow_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  output logic              host_rdy_o,
  output logic              ide_cs0_o,
  output logic [2:0]        ide_da_o,
  output logic              ide_dior_o,
  output logic              ide_diow_o,
  output logic [15:0]       ide_wdata_o,
  input  logic [15:0]       ide_rdata_i
);
  typedef enum logic [1:0] {H_IDLE, H_WAIT, H_DONE} hst_e;

  reg_kind_e   kind;
  hst_e        hst_q;
  drv_op_e     op_q, op_d;
  logic        req, req_q, start, is_rd;
  logic        phase_q;
  logic [7:0]  hi_q;
  logic [7:0]  rdata_q;
  logic        seq_start, seq_wr, seq_done;
  logic [2:0]  seq_da;
  logic [15:0] seq_wd, seq_rd;

  isa_ide_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i        (host_addr_i),
    .aen_i         (host_aen_i),
    .base_i        (base_i),
    .toggle_mode_i (toggle_mode_i),
    .kind_o        (kind)
  );

  assign req   = host_ior_i | host_iow_i;
  assign is_rd = host_ior_i;
  assign start = (hst_q == H_IDLE) && req && !req_q && (kind != REG_NONE);

  // decide whether this host byte needs the drive
  always_comb begin
    seq_start = 1'b0;
    seq_wr    = !is_rd;
    seq_da    = host_addr_i[2:0];
    seq_wd    = {hi_q, host_wdata_i};
    op_d      = is_rd ? OP_RD_WORD : OP_WR;
    if (start) begin
      unique case (kind)
        REG_DATA: seq_start = !toggle_mode_i || (is_rd ? !phase_q : phase_q);
        REG_TASK: begin
          seq_start = 1'b1;
          seq_wd    = {8'h00, host_wdata_i};
          op_d      = is_rd ? OP_RD_BYTE : OP_WR;
        end
        default: ;
      endcase
    end
  end

  isa_ide_drv_seq #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (seq_start),
    .wr_i        (seq_wr),
    .da_i        (seq_da),
    .wdata_i     (seq_wd),
    .ide_rdata_i (ide_rdata_i),
    .cs_o        (ide_cs0_o),
    .da_o        (ide_da_o),
    .dior_o      (ide_dior_o),
    .diow_o      (ide_diow_o),
    .wdata_o     (ide_wdata_o),
    .done_o      (seq_done),
    .rdata_o     (seq_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hst_q   <= H_IDLE;
      op_q    <= OP_WR;
      req_q   <= 1'b0;
      phase_q <= 1'b0;
      hi_q    <= '0;
      rdata_q <= '0;
    end else begin
      req_q <= req;
      unique case (hst_q)
        H_IDLE: if (start) begin
          op_q  <= op_d;
          hst_q <= seq_start ? H_WAIT : H_DONE;
          unique case (kind)
            REG_DATA: begin
              if (toggle_mode_i) phase_q <= ~phase_q;
              if (!seq_start) begin
                if (is_rd) rdata_q <= hi_q;
                else       hi_q    <= host_wdata_i;
              end
            end
            REG_TASK: phase_q <= 1'b0;
            REG_HIGH: begin
              if (is_rd) rdata_q <= hi_q;
              else       hi_q    <= host_wdata_i;
            end
            REG_SPARE: begin
              phase_q <= 1'b0;
              if (is_rd) rdata_q <= 8'hFF;
            end
            default: ;
          endcase
        end
        H_WAIT: if (seq_done) begin
          hst_q <= H_DONE;
          unique case (op_q)
            OP_RD_WORD: begin
              rdata_q <= seq_rd[7:0];
              hi_q    <= seq_rd[15:8];
            end
            OP_RD_BYTE: rdata_q <= seq_rd[7:0];
            default: ;
          endcase
        end
        H_DONE: if (!req) hst_q <= H_IDLE;
        default: hst_q <= H_IDLE;
      endcase
    end
  end

  assign host_rdy_o   = (hst_q == H_DONE);
  assign host_rdata_o = rdata_q;
endmodule

// File: rtl/isa_ide_bridge_chk.sv
module isa_ide_bridge_chk #(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        host_aen_i,
  input logic        host_ior_i,
  input logic        host_iow_i,
  input logic        host_rdy_o,
  input logic        ide_cs0_o,
  input logic        ide_dior_o,
  input logic        ide_diow_o,
  input logic [15:0] ide_wdata_o
);
  logic        strb;
  logic [15:0] pw_cnt, su_cnt;

  assign strb = ide_dior_o | ide_diow_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_cnt <= '0;
      su_cnt <= '0;
    end else begin
      pw_cnt <= strb ? pw_cnt + 1'b1 : '0;
      if (!ide_cs0_o)  su_cnt <= '0;
      else if (!strb)  su_cnt <= su_cnt + 1'b1;
    end
  end

  p_one_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ide_dior_o && ide_diow_o));
  p_strobe_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb |-> ide_cs0_o);
  p_pulse_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb) |-> (pw_cnt == 16'(PULSE_CYC)));
  p_setup_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strb) |-> (su_cnt == 16'(SETUP_CYC)));
  p_wdata_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ide_diow_o && $past(ide_diow_o)) |-> $stable(ide_wdata_o));
  p_rdy_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rdy_o |-> !strb);
  p_rdy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rdy_o && (host_ior_i || host_iow_i)) |=> host_rdy_o);
  p_aen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ide_cs0_o) |-> $past(!host_aen_i));
endmodule

bind isa_ide_bridge isa_ide_bridge_chk #(
  .SETUP_CYC(SETUP_CYC),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_aen_i  (host_aen_i),
  .host_ior_i  (host_ior_i),
  .host_iow_i  (host_iow_i),
  .host_rdy_o  (host_rdy_o),
  .ide_cs0_o   (ide_cs0_o),
  .ide_dior_o  (ide_dior_o),
  .ide_diow_o  (ide_diow_o),
  .ide_wdata_o (ide_wdata_o)
);

// File: tb/isa_ide_bridge_tb.sv
module isa_ide_bridge_tb;
  localparam int SETUP_CYC = 2;
  localparam int PULSE_CYC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        toggle = 1'b0;
  logic [5:0]  base = 6'h30;
  logic [9:0]  addr = '0;
  logic        aen = 1'b0, ior = 1'b0, iow = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdy, cs0, dior, diow;
  logic [2:0]  da;
  logic [15:0] ide_wd, ide_rd;

  logic [15:0] drv_reg [8];
  logic        pre_en = 1'b0;
  logic [2:0]  pre_idx = '0;
  logic [15:0] pre_val = '0;
  int          n_strobe = 0, last_pw = 0, last_su = 0, pw_cnt = 0, su_cnt = 0;
  logic        strb_prev = 1'b0;
  logic [2:0]  last_da = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  isa_ide_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .toggle_mode_i(toggle), .base_i(base),
    .host_addr_i(addr), .host_aen_i(aen), .host_ior_i(ior), .host_iow_i(iow),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .host_rdy_o(rdy),
    .ide_cs0_o(cs0), .ide_da_o(da), .ide_dior_o(dior), .ide_diow_o(diow),
    .ide_wdata_o(ide_wd), .ide_rdata_i(ide_rd)
  );

  assign ide_rd = drv_reg[da];

  // drive model, sampled away from the active edge
  always @(negedge clk) begin
    if (pre_en) drv_reg[pre_idx] <= pre_val;
    else if (diow) drv_reg[da] <= ide_wd;
    if ((dior || diow) && !strb_prev) begin
      n_strobe <= n_strobe + 1;
      last_su  <= su_cnt;
      last_da  <= da;
    end
    if (dior || diow) pw_cnt <= pw_cnt + 1;
    else begin
      if (strb_prev) last_pw <= pw_cnt;
      pw_cnt <= 0;
    end
    if (!cs0) su_cnt <= 0;
    else if (!(dior || diow)) su_cnt <= su_cnt + 1;
    strb_prev <= dior || diow;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preset(input logic [2:0] idx, input logic [15:0] val);
    @(posedge clk);
    pre_idx = idx; pre_val = val; pre_en = 1'b1;
    @(negedge clk);
    #1 pre_en = 1'b0;
  endtask

  task automatic host_cycle(input bit wr, input logic [9:0] a, input logic [7:0] wd,
                            output logic [7:0] rd, output bit ok);
    @(negedge clk);
    addr = a; wdata = wd; ior = !wr; iow = wr;
    ok = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rdy) begin ok = 1'b1; break; end
    end
    rd = rdata;
    ior = 1'b0; iow = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0; toggle = mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] rd; bit ok;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 rdy in reset", rdy, 0);
    chk("R10 strobes/cs in reset", {cs0, dior, diow}, 0);
    rst_n = 1'b1; toggle = 1'b0;
    @(negedge clk);
    host_cycle(1'b0, 10'h308, 8'h00, rd, ok);
    chk("R10 high latch cleared", rd, 8'h00);
  endtask

  task automatic t_split_read;
    logic [7:0] rd; bit ok; int s0;
    preset(3'd0, 16'hA55A);
    s0 = n_strobe;
    host_cycle(1'b0, 10'h300, 8'h00, rd, ok);
    chk("R3 split low byte", rd, 8'h5A);
    chk("R3 one drive read", 16'(n_strobe - s0), 1);
    chk("R8 pulse width", 16'(last_pw), PULSE_CYC);
    chk("R8 setup", 16'(last_su), SETUP_CYC);
    s0 = n_strobe;
    host_cycle(1'b0, 10'h308, 8'h00, rd, ok);
    chk("R3 split high byte", rd, 8'hA5);
    chk("R3 no strobe at +8", 16'(n_strobe - s0), 0);
  endtask

  task automatic t_split_write;
    logic [7:0] rd; bit ok; int s0;
    s0 = n_strobe;
    host_cycle(1'b1, 10'h308, 8'h12, rd, ok);
    chk("R4 no strobe on high write", 16'(n_strobe - s0), 0);
    chk("R9 rdy on latch write", ok, 1);
    host_cycle(1'b1, 10'h300, 8'h34, rd, ok);
    chk("R4 one drive write", 16'(n_strobe - s0), 1);
    chk("R4 word written", drv_reg[0], 16'h1234);
  endtask

  task automatic t_taskfile;
    logic [7:0] rd; bit ok; int s0;
    preset(3'd1, 16'h77E7);
    s0 = n_strobe;
    host_cycle(1'b0, 10'h301, 8'h00, rd, ok);
    chk("R2 error reg read", rd, 8'hE7);
    chk("R2 da on read", last_da, 3'd1);
    host_cycle(1'b1, 10'h307, 8'h20, rd, ok);
    chk("R2 command write", drv_reg[7], 16'h0020);
    chk("R2 da on write", last_da, 3'd7);
    chk("R2 strobes", 16'(n_strobe - s0), 2);
  endtask

  task automatic t_spare;
    logic [7:0] rd; bit ok; int s0;
    s0 = n_strobe;
    host_cycle(1'b0, 10'h30C, 8'h00, rd, ok);
    chk("R11 spare read", rd, 8'hFF);
    chk("R11 no strobe", 16'(n_strobe - s0), 0);
  endtask

  task automatic t_toggle_read;
    logic [7:0] rd; bit ok; int s0;
    do_reset(1'b1);
    preset(3'd0, 16'hBEEF);
    s0 = n_strobe;
    host_cycle(1'b0, 10'h300, 8'h00, rd, ok);
    chk("R5 toggle first byte", rd, 8'hEF);
    chk("R5 first strobes", 16'(n_strobe - s0), 1);
    host_cycle(1'b0, 10'h300, 8'h00, rd, ok);
    chk("R5 toggle second byte", rd, 8'hBE);
    chk("R5 no strobe second", 16'(n_strobe - s0), 1);
  endtask

  task automatic t_toggle_write;
    logic [7:0] rd; bit ok; int s0;
    s0 = n_strobe;
    host_cycle(1'b1, 10'h300, 8'hCA, rd, ok);
    chk("R6 no strobe first write", 16'(n_strobe - s0), 0);
    host_cycle(1'b1, 10'h300, 8'hFE, rd, ok);
    chk("R6 one drive write", 16'(n_strobe - s0), 1);
    chk("R6 word order", drv_reg[0], 16'hCAFE);
  endtask

  task automatic t_toggle_reset;
    logic [7:0] rd; bit ok; int s0;
    preset(3'd0, 16'h1357);
    preset(3'd7, 16'h0050);
    host_cycle(1'b0, 10'h300, 8'h00, rd, ok);
    chk("R7 low byte before status", rd, 8'h57);
    host_cycle(1'b0, 10'h307, 8'h00, rd, ok);
    chk("R7 status read", rd, 8'h50);
    s0 = n_strobe;
    host_cycle(1'b0, 10'h300, 8'h00, rd, ok);
    chk("R7 phase reset low byte", rd, 8'h57);
    chk("R7 phase reset strobes", 16'(n_strobe - s0), 1);
  endtask

  task automatic t_decode;
    logic [7:0] rd; bit ok; int s0;
    do_reset(1'b0);
    preset(3'd0, 16'h4C3B);
    s0 = n_strobe;
    aen = 1'b1;
    host_cycle(1'b0, 10'h300, 8'h00, rd, ok);
    aen = 1'b0;
    chk("R1 aen blocks rdy", ok, 0);
    chk("R1 aen blocks strobe", 16'(n_strobe - s0), 0);
    base = 6'h36;
    host_cycle(1'b0, 10'h300, 8'h00, rd, ok);
    chk("R1 old base ignored", {ok, 16'(n_strobe - s0)}, 0);
    host_cycle(1'b0, 10'h360, 8'h00, rd, ok);
    chk("R1 relocated base low", rd, 8'h3B);
    chk("R1 relocated base rdy", ok, 1);
    base = 6'h30;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) drv_reg[i] = '0;
    repeat (2) @(negedge clk);
    t_reset();
    t_split_read();
    t_split_write();
    t_taskfile();
    t_spare();
    t_toggle_read();
    t_toggle_write();
    t_toggle_reset();
    t_decode();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule